// File: doc/BRIEF.md
# SD Command-Line Engine

This block owns the command wire of an SD or MMC card interface. On a start strobe it builds a 48-bit command frame from a 6-bit command index and a 32-bit argument. It computes the frame checksum and shifts the frame out most significant bit first, one bit on each clock where the SD clock enable is high. It can then listen on the same wire for the card's reply. It waits for the reply's start bit and captures a programmable number of reply bits. It checks the reply checksum, and it can wait for the card to release DAT0 before it reports completion.

The host side programs the reply length in bits minus one: 45 for the short replies and 133 for the long identification reply. A length of zero means no reply is expected. Three mode flags control the reply handling:

- one skips the seven header bits in the checksum, which the long reply needs;
- one turns checking off, which the operating-condition reply needs;
- one adds the DAT0 busy wait, which a stop command needs.

Software treats a command as finished when `busy` is low and `done` is high. A soft reset input abandons any command in flight.

Top module: `sd_cmd_engine`

## Requirements
- R1: An accepted command drives `cmd_oe` high for exactly 48 bit slots and emits, most significant bit first: 0, 1, cmd_idx[5:0], cmd_arg[31:0], the 7-bit CRC, then 1. Each slot advances only on a clock with `sd_ce` high, and `cmd_out` holds while `sd_ce` is low. `cmd_out` is 1 whenever `cmd_oe` is low.
- R2: The CRC is polynomial x^7+x^3+1 with a zero start value, taken over the first 40 frame bits. Index 0 with argument 0 gives frame 0x400000000095, and index 8 with argument 0x1AA gives 0x48000001AA87.
- R3: With `resp_len` = 0 no reply is awaited. `done` rises on the edge that ends the 48th bit slot, with `crc_ok` = 1.
- R4: With `resp_len` = L > 0, after the frame the engine waits for `cmd_in` = 0 on an enabled clock. It then captures the next L+1 enabled `cmd_in` samples into `resp_data`, shifting in at bit 0 so that the last sample ends at bit 0. Higher bits are zero, and the reply end bit is not captured.
- R5: At the end of a reply, `crc_ok` = 1 exactly when the CRC of the covered captured bits has zero remainder, meaning the last 7 captured bits equal the CRC of the covered bits before them. All captured bits are covered, or all but the first 7 when `crc_skip_hdr` = 1.
- R6: With `crc_off` = 1, `crc_ok` ends at 1 for any reply content.
- R7: If `cmd_in` stays high for 64 enabled clocks after the frame, the engine ends with `resp_timeout` = 1, `crc_ok` = 0 and `done` = 1, with no busy wait. A start bit on the 64th enabled clock is still accepted.
- R8: With `wait_busy` = 1, after the reply (or after the frame when there is no reply) `done` stays low and `busy` stays high until `dat0_in` is sampled high on an enabled clock. `done` then rises on that edge.
- R9: `busy` is high from the edge that accepts `start` until completion. `done` clears on acceptance and stays high until the next accepted start. A `start` pulse while busy is ignored and leaves the frame in flight unchanged.
- R10: `soft_rst` returns the engine to idle on the next edge: `busy`, `done` and `cmd_oe` are 0 and `resp_data` is zero. The next command runs normally.
- R11: After `rst`: `busy`, `done`, `cmd_oe`, `crc_ok`, `resp_timeout` are 0, `cmd_out` is 1 and `resp_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Abort the current command and go idle |
| start | input | 1 | Launch a command when idle |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_len | input | 8 | Reply bits minus one; 0 means no reply |
| crc_skip_hdr | input | 1 | Exclude the first 7 reply bits from the CRC |
| crc_off | input | 1 | Report the reply CRC as good unconditionally |
| wait_busy | input | 1 | Wait for DAT0 high before completing |
| sd_ce | input | 1 | SD clock enable; one bit slot per enabled clock |
| cmd_in | input | 1 | Sampled CMD wire |
| dat0_in | input | 1 | Sampled DAT0 wire |
| cmd_out | output | 1 | CMD wire drive value |
| cmd_oe | output | 1 | CMD wire drive enable |
| resp_data | output | 136 | Captured reply bits, last bit at bit 0 |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command complete |
| crc_ok | output | 1 | Reply CRC good |
| resp_timeout | output | 1 | No reply start bit seen |

## Verification
A wrong bit counter shows at the ports on the very next command. The frame comes out with the wrong length, visible in how long `cmd_oe` stays high, or the reply lands shifted in `resp_data` when `done` rises. A corrupted CRC register or a wrong header-skip count shows as a wrong `crc_ok` at the end of the reply. The bench sweeps every single-bit error position, so each such fault is caught within one command. A stuck hunt counter or busy-wait state shows as `done` rising a cycle early or late against the 64-clock boundary, or against the DAT0 release edge.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    localparam int FRAME_BITS = 48;
    localparam int CRC_BITS   = 7;
    localparam int HDR_BITS   = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_HUNT,
        ST_RECV,
        ST_BUSYW
    } eng_state_e;

    typedef struct packed {
        logic skip_hdr;
        logic no_crc;
        logic busy_chk;
    } mode_t;

    // One serial step of the x^7+x^3+1 checksum
    function automatic logic [CRC_BITS-1:0] crc7_step(input logic [CRC_BITS-1:0] c,
                                                      input logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:3], c[2] ^ fb, c[1:0], fb};
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input logic [5:0]  idx,
                                                          input logic [31:0] arg);
        logic [39:0]          body;
        logic [CRC_BITS-1:0]  c;
        body = {2'b01, idx, arg};
        c    = '0;
        for (int i = 39; i >= 0; i--) c = crc7_step(c, body[i]);
        return {body, c, 1'b1};
    endfunction

endpackage

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx #(
    parameter int FRAME_W = 48
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic               shift,
    output logic               bit_o
);
    logic [FRAME_W-1:0] shreg_q;

    // Ones fill in behind the frame so the idle line level is high
    always_ff @(posedge clk) begin
        if (rst)        shreg_q <= '1;
        else if (load)  shreg_q <= frame;
        else if (shift) shreg_q <= {shreg_q[FRAME_W-2:0], 1'b1};
    end

    assign bit_o = shreg_q[FRAME_W-1];
endmodule

// File: rtl/sd_cmd_rx.sv
module sd_cmd_rx
    import sd_cmd_pkg::*;
#(
    parameter int RESP_W = 136
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                take,
    input  logic                bit_i,
    input  logic                crc_en,
    output logic [RESP_W-1:0]   resp,
    output logic [CRC_BITS-1:0] crc_next
);
    logic [RESP_W-1:0]   resp_q;
    logic [CRC_BITS-1:0] crc_q;

    assign crc_next = crc_en ? crc7_step(crc_q, bit_i) : crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            resp_q <= '0;
            crc_q  <= '0;
        end else if (take) begin
            resp_q <= {resp_q[RESP_W-2:0], bit_i};
            crc_q  <= crc_next;
        end
    end

    assign resp = resp_q;
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sd_cmd_pkg::*;
#(
    parameter int RESP_BYTES = 17,
    parameter int LEN_W      = 8,
    parameter int HUNT_LIMIT = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    soft_rst,
    input  logic                    start,
    input  logic [5:0]              cmd_idx,
    input  logic [31:0]             cmd_arg,
    input  logic [LEN_W-1:0]        resp_len,
    input  logic                    crc_skip_hdr,
    input  logic                    crc_off,
    input  logic                    wait_busy,
    input  logic                    sd_ce,
    input  logic                    cmd_in,
    input  logic                    dat0_in,
    output logic                    cmd_out,
    output logic                    cmd_oe,
    output logic [RESP_BYTES*8-1:0] resp_data,
    output logic                    busy,
    output logic                    done,
    output logic                    crc_ok,
    output logic                    resp_timeout
);
    localparam int RESP_W = RESP_BYTES * 8;
    localparam int HUNT_W = $clog2(HUNT_LIMIT);

    eng_state_e          state_q;
    mode_t               mode_q;
    logic [LEN_W-1:0]    cnt_q;
    logic [LEN_W-1:0]    len_q;
    logic [2:0]          hdr_q;
    logic [HUNT_W-1:0]   hunt_q;
    logic                done_q, crc_ok_q, tmo_q;
    logic                busy_chk_q;

    logic                abort;
    logic                accept;
    logic                tx_shift;
    logic                rx_take;
    logic                rx_crc_en;
    logic [CRC_BITS-1:0] crc_next;

    assign abort     = rst | soft_rst;
    assign accept    = start && (state_q == ST_IDLE);
    assign tx_shift  = (state_q == ST_SEND) && sd_ce;
    assign rx_take   = (state_q == ST_RECV) && sd_ce;
    assign rx_crc_en = !mode_q.skip_hdr || (hdr_q == 3'(HDR_BITS));
    assign busy_chk_q = mode_q.busy_chk;

    sd_cmd_tx #(.FRAME_W(FRAME_BITS)) u_tx (
        .clk   (clk),
        .rst   (abort),
        .load  (accept),
        .frame (build_frame(cmd_idx, cmd_arg)),
        .shift (tx_shift),
        .bit_o (cmd_out)
    );

    sd_cmd_rx #(.RESP_W(RESP_W)) u_rx (
        .clk      (clk),
        .rst      (abort),
        .clr      (accept),
        .take     (rx_take),
        .bit_i    (cmd_in),
        .crc_en   (rx_crc_en),
        .resp     (resp_data),
        .crc_next (crc_next)
    );

    always_ff @(posedge clk) begin
        if (abort) begin
            state_q  <= ST_IDLE;
            mode_q   <= '0;
            cnt_q    <= '0;
            len_q    <= '0;
            hdr_q    <= '0;
            hunt_q   <= '0;
            done_q   <= 1'b0;
            crc_ok_q <= 1'b0;
            tmo_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q  <= ST_SEND;
                    cnt_q    <= LEN_W'(FRAME_BITS - 1);
                    len_q    <= resp_len;
                    mode_q   <= '{skip_hdr: crc_skip_hdr, no_crc: crc_off, busy_chk: wait_busy};
                    hdr_q    <= '0;
                    hunt_q   <= '0;
                    done_q   <= 1'b0;
                    crc_ok_q <= 1'b1;
                    tmo_q    <= 1'b0;
                end
                ST_SEND: if (sd_ce) begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (len_q != '0) begin
                        state_q <= ST_HUNT;
                    end else if (mode_q.busy_chk) begin
                        state_q <= ST_BUSYW;
                    end else begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                ST_HUNT: if (sd_ce) begin
                    if (!cmd_in) begin
                        state_q <= ST_RECV;
                        cnt_q   <= len_q;
                    end else if (hunt_q == HUNT_W'(HUNT_LIMIT - 1)) begin
                        state_q  <= ST_IDLE;
                        tmo_q    <= 1'b1;
                        crc_ok_q <= 1'b0;
                        done_q   <= 1'b1;
                    end else begin
                        hunt_q <= hunt_q + 1'b1;
                    end
                end
                ST_RECV: if (sd_ce) begin
                    if (hdr_q != 3'(HDR_BITS)) hdr_q <= hdr_q + 1'b1;
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else begin
                        crc_ok_q <= mode_q.no_crc | (crc_next == '0);
                        if (mode_q.busy_chk) begin
                            state_q <= ST_BUSYW;
                        end else begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                ST_BUSYW: if (sd_ce && dat0_in) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cmd_oe       = (state_q == ST_SEND);
    assign busy         = (state_q != ST_IDLE);
    assign done         = done_q;
    assign crc_ok       = crc_ok_q;
    assign resp_timeout = tmo_q;
endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk (
    input logic clk,
    input logic rst,
    input logic soft_rst,
    input logic start,
    input logic sd_ce,
    input logic dat0_in,
    input logic cmd_out,
    input logic cmd_oe,
    input logic busy,
    input logic done,
    input logic crc_ok,
    input logic resp_timeout,
    input logic busy_chk_q
);
    AST_OE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        cmd_oe |-> busy);                                                       // R1

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !cmd_oe |-> cmd_out);                                                   // R1

    AST_HOLD_WITHOUT_CE: assert property (@(posedge clk) disable iff (rst)
        busy && !sd_ce && !soft_rst |=> $stable(cmd_out) && $stable(cmd_oe));   // R1

    AST_DONE_EXCLUDES_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                                        // R9

    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
        start && !busy && !soft_rst |=> busy && !done);                         // R9

    AST_TIMEOUT_BAD_CRC: assert property (@(posedge clk) disable iff (rst)
        resp_timeout |-> !crc_ok);                                              // R7

    AST_BUSY_WAIT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(done) && busy_chk_q && !resp_timeout |-> $past(dat0_in));         // R8

    AST_SOFT_ABORT: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !busy && !done && !cmd_oe);                                // R10
endmodule

bind sd_cmd_engine sd_cmd_engine_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .soft_rst     (soft_rst),
    .start        (start),
    .sd_ce        (sd_ce),
    .dat0_in      (dat0_in),
    .cmd_out      (cmd_out),
    .cmd_oe       (cmd_oe),
    .busy         (busy),
    .done         (done),
    .crc_ok       (crc_ok),
    .resp_timeout (resp_timeout),
    .busy_chk_q   (busy_chk_q)
);

// File: tb/sd_cmd_engine_bench.sv
module sd_cmd_engine_bench;
    logic         clk = 1'b0;
    logic         rst, soft_rst, start;
    logic [5:0]   cmd_idx;
    logic [31:0]  cmd_arg;
    logic [7:0]   resp_len;
    logic         crc_skip_hdr, crc_off, wait_busy, sd_ce, cmd_in, dat0_in;
    logic         cmd_out, cmd_oe, busy, done, crc_ok, resp_timeout;
    logic [135:0] resp_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sd_cmd_engine u_sd_cmd_engine (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .start(start),
        .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .resp_len(resp_len),
        .crc_skip_hdr(crc_skip_hdr), .crc_off(crc_off), .wait_busy(wait_busy),
        .sd_ce(sd_ce), .cmd_in(cmd_in), .dat0_in(dat0_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .resp_data(resp_data),
        .busy(busy), .done(done), .crc_ok(crc_ok), .resp_timeout(resp_timeout)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [135:0] act, input logic [135:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Remainder of M(x)*x^7 modulo x^7+x^3+1, by long division
    function automatic logic [6:0] ref_crc(input logic [135:0] v, input int n);
        logic [6:0] r = '0;
        logic       top;
        for (int i = n + 6; i >= 0; i--) begin
            top = r[6];
            r   = {r[5:0], (i >= 7) ? v[i-7] : 1'b0};
            if (top) r = r ^ 7'h09;
        end
        return r;
    endfunction

    function automatic logic [47:0] ref_frame(input logic [5:0] idx, input logic [31:0] arg);
        logic [39:0] m = {2'b01, idx, arg};
        return {m, ref_crc(136'(m), 40), 1'b1};
    endfunction

    task automatic send_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [7:0] len,
                            input bit skip, input bit off, input bit wb, input int ce_div,
                            input int inj_start, input int inj_srst,
                            output logic [47:0] got, output int n);
        int c = 0;
        @(negedge clk);
        cmd_idx = idx; cmd_arg = arg; resp_len = len;
        crc_skip_hdr = skip; crc_off = off; wait_busy = wb; sd_ce = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = '0; n = 0;
        while (cmd_oe && c < 2000) begin
            sd_ce    = (c % ce_div) == 0;
            start    = (c == inj_start);
            cmd_idx  = (c == inj_start) ? ~idx : idx;
            soft_rst = (c == inj_srst);
            if (sd_ce) begin
                got = {got[46:0], cmd_out};
                n++;
            end
            @(negedge clk);
            c++;
        end
        start = 1'b0; soft_rst = 1'b0; sd_ce = 1'b1; cmd_idx = idx;
    endtask

    task automatic respond(input logic [135:0] bits, input int nb, input int gap);
        cmd_in = 1'b1;
        repeat (gap) @(negedge clk);
        cmd_in = 1'b0;
        @(negedge clk);
        for (int i = nb - 1; i >= 0; i--) begin
            cmd_in = bits[i];
            @(negedge clk);
        end
        cmd_in = 1'b1;
    endtask

    task automatic wait_idle();
        int k = 0;
        while (busy && k < 1000) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [47:0]  got;
        int           n;
        logic [38:0]  m39;
        logic [45:0]  b46;
        logic [133:0] b134;
        logic [127:0] pay;
        logic [6:0]   cc;
        bit           expok;
        int           k;

        rst = 1'b1; soft_rst = 1'b0; start = 1'b0; cmd_idx = '0; cmd_arg = '0;
        resp_len = '0; crc_skip_hdr = 1'b0; crc_off = 1'b0; wait_busy = 1'b0;
        sd_ce = 1'b1; cmd_in = 1'b1; dat0_in = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(!busy && !done && !cmd_oe, "R11 idle flags", {busy, done, cmd_oe}, 0);
        chk(cmd_out == 1'b1, "R11 idle line", cmd_out, 1);
        chk(!crc_ok && !resp_timeout, "R11 status", {crc_ok, resp_timeout}, 0);
        chk(resp_data == '0, "R11 resp", resp_data, 0);

        // R2 fixed vectors
        send_cmd(6'd0, 32'h0, 8'd0, 0, 0, 0, 1, -1, -1, got, n);
        chk(got == 48'h400000000095, "R2 idx0 frame", got, 48'h400000000095);
        chk(done && !busy && crc_ok, "R3 done after frame", {done, busy, crc_ok}, 3'b101);
        send_cmd(6'd8, 32'h1AA, 8'd0, 0, 0, 0, 1, -1, -1, got, n);
        chk(got == 48'h48000001AA87, "R2 idx8 frame", got, 48'h48000001AA87);

        // R1 R2 sweep of every index under three enable rates
        for (int i = 0; i < 64; i++) begin
            logic [31:0] a;
            a = (i == 1) ? 32'hFFFFFFFF : $urandom;
            send_cmd(6'(i), a, 8'd0, 0, 0, 0, 1 + (i % 3), -1, -1, got, n);
            chk(got == ref_frame(6'(i), a), "R1 R2 frame sweep", got, ref_frame(6'(i), a));
            chk(n == 48, "R1 bit slot count", n, 48);
            chk(done && !busy, "R3 completion", {done, busy}, 2'b10);
        end

        // R9 start while busy ignored; busy/done flags during a command
        @(negedge clk);
        cmd_idx = 6'd5; cmd_arg = 32'hCAFE0001; resp_len = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done, "R9 busy after accept", {busy, done}, 2'b10);
        wait_idle();
        send_cmd(6'd12, 32'h12345678, 8'd0, 0, 0, 0, 1, 10, -1, got, n);
        chk(got == ref_frame(6'd12, 32'h12345678), "R9 ignored start", got, ref_frame(6'd12, 32'h12345678));

        // R4 R5 short replies, various start-bit gaps
        for (int r = 0; r < 16; r++) begin
            m39 = {1'b0, 6'(r + 1), 32'($urandom)};
            b46 = {m39, ref_crc(136'(m39), 39)};
            send_cmd(6'(r + 1), 32'(r), 8'd45, 0, 0, 0, 1, -1, -1, got, n);
            respond(136'(b46), 46, r * 4);
            chk(done && !busy, "R4 reply done", {done, busy}, 2'b10);
            chk(resp_data == 136'(b46), "R4 reply data", resp_data, 136'(b46));
            chk(crc_ok && !resp_timeout, "R5 good crc", {crc_ok, resp_timeout}, 2'b10);
        end

        // R5 R6 every single-bit error position
        for (int p = 0; p < 46; p++) begin
            bit off;
            m39  = {1'b0, 6'd17, 32'($urandom)};
            b46  = {m39, ref_crc(136'(m39), 39)} ^ (46'd1 << p);
            off  = (p % 4) == 3;
            expok = off || (ref_crc(136'(b46[45:7]), 39) == b46[6:0]);
            send_cmd(6'd17, 32'h0, 8'd45, 0, off, 0, 1, -1, -1, got, n);
            respond(136'(b46), 46, 2);
            if (off) chk(crc_ok == 1'b1, "R6 check off", crc_ok, 1);
            else     chk(crc_ok == expok, "R5 corrupted bit", crc_ok, expok);
        end

        // R6 operating-condition style reply with all-ones checksum field
        m39 = {1'b0, 6'h3F, 32'h80FF8000};
        b46 = {m39, 7'h7F};
        send_cmd(6'd41, 32'h0, 8'd45, 0, 1, 0, 1, -1, -1, got, n);
        respond(136'(b46), 46, 3);
        chk(crc_ok == 1'b1, "R6 ones field ok", crc_ok, 1);
        send_cmd(6'd41, 32'h0, 8'd45, 0, 0, 0, 1, -1, -1, got, n);
        respond(136'(b46), 46, 3);
        expok = ref_crc(136'(m39), 39) == 7'h7F;
        chk(crc_ok == expok, "R5 ones field checked", crc_ok, expok);

        // R4 R5 long replies with header skip
        for (int r = 0; r < 4; r++) begin
            pay  = {32'($urandom), 32'($urandom), 32'($urandom), 32'($urandom)};
            cc   = ref_crc(136'(pay[119:0]), 120);
            b134 = {7'b0111111, pay[119:0], cc};
            send_cmd(6'd2, 32'h0, 8'd133, 1, 0, 0, 1, -1, -1, got, n);
            respond(136'(b134), 134, r);
            chk(resp_data == 136'(b134), "R4 long data", resp_data, 136'(b134));
            chk(crc_ok == 1'b1, "R5 long skip crc", crc_ok, 1);
            send_cmd(6'd2, 32'h0, 8'd133, 0, 0, 0, 1, -1, -1, got, n);
            respond(136'(b134), 134, r);
            expok = ref_crc(136'(b134), 134) == 7'h00;
            chk(crc_ok == expok, "R5 long no skip", crc_ok, expok);
        end

        // R7 start-bit window boundary
        m39 = {1'b0, 6'd3, 32'h00010000};
        b46 = {m39, ref_crc(136'(m39), 39)};
        send_cmd(6'd3, 32'h0, 8'd45, 0, 0, 0, 1, -1, -1, got, n);
        respond(136'(b46), 46, 63);
        chk(!resp_timeout && crc_ok && resp_data == 136'(b46), "R7 gap 63 accepted",
            resp_timeout, 0);
        send_cmd(6'd3, 32'h0, 8'd45, 0, 0, 0, 1, -1, -1, got, n);
        k = 0;
        while (busy && k < 500) begin
            @(negedge clk);
            k++;
        end
        chk(k == 64, "R7 timeout cycles", k, 64);
        chk(resp_timeout && !crc_ok && done, "R7 timeout flags",
            {resp_timeout, crc_ok, done}, 3'b101);

        // R8 busy wait after a reply and after a bare command
        dat0_in = 1'b0;
        send_cmd(6'd12, 32'h0, 8'd45, 0, 0, 1, 1, -1, -1, got, n);
        respond(136'(b46), 46, 1);
        repeat (20) @(negedge clk);
        chk(busy && !done, "R8 held while dat0 low", {busy, done}, 2'b10);
        dat0_in = 1'b1;
        @(negedge clk);
        chk(done && !busy, "R8 release", {done, busy}, 2'b10);
        dat0_in = 1'b0;
        send_cmd(6'd7, 32'h0, 8'd0, 0, 0, 1, 1, -1, -1, got, n);
        repeat (5) @(negedge clk);
        chk(busy && !done, "R8 no-reply held", {busy, done}, 2'b10);
        dat0_in = 1'b1;
        @(negedge clk);
        chk(done && !busy, "R8 no-reply release", {done, busy}, 2'b10);

        // R10 soft reset during frame and during reply
        send_cmd(6'd9, 32'hA5A5A5A5, 8'd45, 0, 0, 0, 1, -1, 20, got, n);
        chk(!busy && !done && !cmd_oe && cmd_out, "R10 abort in frame",
            {busy, done, cmd_oe, cmd_out}, 4'b0001);
        send_cmd(6'd9, 32'h0, 8'd45, 0, 0, 0, 1, -1, -1, got, n);
        cmd_in = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            cmd_in = i[0];
            @(negedge clk);
        end
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0; cmd_in = 1'b1;
        chk(!busy && !done && resp_data == '0, "R10 abort in reply", resp_data, 0);
        m39 = {1'b0, 6'd13, 32'h00000900};
        b46 = {m39, ref_crc(136'(m39), 39)};
        send_cmd(6'd13, 32'h0, 8'd45, 0, 0, 0, 1, -1, -1, got, n);
        respond(136'(b46), 46, 0);
        chk(resp_data == 136'(b46) && crc_ok && done, "R10 resume", resp_data, 136'(b46));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule